// File: doc/BRIEF.md
# Serial ADC Read Sequencer (SPI Mode 0 Host)

This block is the host side of a link to an 8-bit successive-approximation converter that takes a one-byte command on its serial input. The converter runs its conversion from the serial clock. A single request carries a channel number, a single-ended or differential flag, a unipolar or bipolar flag, and a framing choice. The sequencer builds the command byte, pulls chip select low and drives the serial clock from a programmable divider. It then recovers the result bits from the returned stream and hands each result back with a one-cycle valid strobe.

There are two framings. The byte-aligned framing uses 24 serial clocks: one command byte, then two all-zero bytes. The 8-bit result straddles the two received bytes, behind two leading zeros and ahead of six trailing zeros. The streaming framing repeats the same command once per 10-clock slot. Each new start bit goes out on the same clock that returns the previous result's most significant bit, so one result arrives every ten serial clocks. A watchdog timer bounds how long chip select may stay low. If the transaction runs too long, it is aborted and an error flag is raised.

Top module: `adc_spi_reader`

## Requirements
- R1: SPI mode 0 holds throughout: `spi_sclk` is low while `spi_cs_n` is high, `spi_mosi` never changes while `spi_sclk` is high, and `spi_miso` is sampled on rising edges of `spi_sclk`.
- R2: The command byte is sent MSB first. Bit 7 is 1 (start), bits 6:4 are `req_chan`, bit 3 is `req_unipolar`, bit 2 is `req_single`, and bits 1:0 are 11 (converter stays powered and uses the serial clock to convert).
- R3: Byte-aligned framing (`req_stream`=0) gives exactly 24 rising edges per chip-select window, and MOSI is 0 on edges 9 to 24. The result is the six low bits of the second received byte followed by the two high bits of the third, i.e. the bits sampled on rising edges 11 to 18, MSB first.
- R4: Streaming framing (`req_stream`=1) runs N = `req_count`+1 conversions. Command byte k starts on rising edge 10k+1, MOSI is 0 outside the command bytes, result k is sampled on rising edges 10k+11 to 10k+18, and the window holds exactly 10N+8 rising edges.
- R5: Each completed conversion produces exactly one single-cycle `res_valid` pulse, in conversion order, while chip select is low.
- R6: `res_ext` is `res_data` zero-extended to 9 bits when the request was unipolar, and sign-extended (two's complement) when it was bipolar.
- R7: Each SCLK high phase and low phase lasts DIV_HALF system clocks. Chip select falls exactly DIV_HALF clocks before the first rising edge and rises DIV_HALF clocks after the last falling edge.
- R8: `req_ready` is high only while no transaction is running. A request presented while busy is ignored and does not change the command bytes of the running transaction.
- R9: When a transaction has been busy for TIMEOUT_CYC clocks, it is aborted: chip select rises, SCLK goes low, and `err_timeout` is set. `err_timeout` stays set until the next request is accepted, which clears it.
- R10: After reset, `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, `req_ready`=1, `res_valid`=0 and `err_timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_chan | input | 3 | Channel select field of the command byte |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_unipolar | input | 1 | 1 = unipolar (unsigned), 0 = bipolar (two's complement) |
| req_stream | input | 1 | 0 = 24-clock byte framing, 1 = 10-clock streaming |
| req_count | input | CNT_W | Streaming conversions minus one |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | 8 | Raw converter result |
| res_ext | output | 9 | Result extended by polarity |
| err_timeout | output | 1 | Last transaction exceeded the time limit |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Result data from the converter |

## Verification
The bench builds the block with DIV_HALF=2, TIMEOUT_CYC=600 and CNT_W=4. A short divider keeps the run brief while still giving a serial clock with distinct high and low phases. With these values, streams of up to twelve conversions finish in time. A request for sixteen conversions hits the limit partway through, after exactly fourteen results, so the abort path and the error flag can both be reached. A behavioural converter model answers each command byte with a random or directed code. That lets the 0x00, 0x7F, 0x80 and 0xFF sign-extension corners be checked in both polarities.

// File: rtl/adcr_pkg.sv
// Shared constants, state type and command-byte builder for the serial ADC
// read sequencer. Assumes an 8-bit converter with a one-byte command.
package adcr_pkg;
    localparam int RES_W    = 8;   // converter result width
    localparam int CTRL_W   = 8;   // command byte width
    localparam int SLOT_LEN = 10;  // serial clocks per streaming conversion
    localparam int CH_W     = 3;   // channel field width

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_t;

    // Command byte: start, channel, polarity, input type, powered, serial-clock conversion
    function automatic logic [CTRL_W-1:0] make_ctrl(input logic [CH_W-1:0] ch,
                                                     input logic uni,
                                                     input logic sgl);
        return {1'b1, ch, uni, sgl, 2'b11};
    endfunction
endpackage

// File: rtl/adcr_sclk_gen.sv
// Serial clock generator. Divides the system clock by 2*DIV_HALF while run is
// high. A rising toggle happens only when allow_rise is set; falling toggles are
// always allowed. Assumes run drops in the same cycle an abort is decided, so
// the clock returns low together with chip select.
module adcr_sclk_gen #(
    parameter int DIV_HALF = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic allow_rise,
    output logic sclk,
    output logic tick,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [DW-1:0] div_q;
    logic          sclk_q;

    assign tick    = run && (div_q == DW'(DIV_HALF - 1));
    assign rise_ev = tick && !sclk_q && allow_rise;
    assign fall_ev = tick && sclk_q;
    assign sclk    = sclk_q;

    // Half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            div_q <= '0;
            if (sclk_q || allow_rise) sclk_q <= ~sclk_q;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $past(div_q) == DW'(DIV_HALF - 1)); // R7
endmodule

// File: rtl/adcr_slot_map.sv
// Bit-level framing map. Given the slot phase and slot index of the next rising
// edge, it gives the MOSI bit for that edge and says whether the edge samples a
// result bit. Assumes edge e maps to ph=(e-1) mod 10 and q=(e-1)/10. Result k
// uses phases 0..7 of slot k+1.
module adcr_slot_map #(
    parameter int CNT_W = 4
) (
    input  logic [3:0]                   ph,
    input  logic [CNT_W:0]               q,
    input  logic [CNT_W:0]               n_conv,
    input  logic [adcr_pkg::CTRL_W-1:0]  ctrl,
    output logic                         tx_bit,
    output logic                         rx_en,
    output logic                         rx_last
);
    localparam int QW = CNT_W + 1;

    logic in_byte;
    logic [QW-1:0] q_m1;

    // Decode command slot and result slot for the next edge
    always_comb begin
        in_byte = (ph < 4'd8);
        q_m1    = q - QW'(1);
        tx_bit  = (q < n_conv) && in_byte ? ctrl[3'd7 - ph[2:0]] : 1'b0;
        rx_en   = (q != '0) && (q_m1 < n_conv) && in_byte;
        rx_last = rx_en && (ph == 4'd7);
    end
endmodule

// File: rtl/adcr_rx_capture.sv
// Result capture. Shifts MISO in on each sampling edge. On the eighth bit it
// publishes the raw result and its polarity-extended form with a one-cycle strobe.
// Assumes exactly eight samples per result, with the last one flagged.
module adcr_rx_capture (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample,
    input  logic                         last,
    input  logic                         miso,
    input  logic                         uni,
    output logic                         res_valid,
    output logic [adcr_pkg::RES_W-1:0]   res_data,
    output logic [adcr_pkg::RES_W:0]     res_ext
);
    localparam int RW = adcr_pkg::RES_W;

    logic [RW-2:0] sh_q;

    // Shift register, result latch and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_ext   <= '0;
        end else begin
            res_valid <= sample && last;
            if (sample) begin
                sh_q <= {sh_q[RW-3:0], miso};
                if (last) begin
                    res_data <= {sh_q, miso};
                    res_ext  <= uni ? {1'b0, sh_q, miso} : {sh_q[RW-2], sh_q, miso};
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R5
endmodule

// File: rtl/adc_spi_reader.sv
// Serial ADC read sequencer, SPI mode 0 host. Takes a request while idle, builds
// the command byte and runs either a 24-clock byte-aligned transaction or a
// streaming transaction of 10 clocks per conversion plus 8. It returns each result
// with a strobe and aborts any transaction that runs past TIMEOUT_CYC clocks.
// Assumes the converter answers in its serial-clock conversion mode.
module adc_spi_reader #(
    parameter int DIV_HALF    = 125,
    parameter int TIMEOUT_CYC = 125000,
    parameter int CNT_W       = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [adcr_pkg::CH_W-1:0]    req_chan,
    input  logic                         req_single,
    input  logic                         req_unipolar,
    input  logic                         req_stream,
    input  logic [CNT_W-1:0]             req_count,
    output logic                         res_valid,
    output logic [adcr_pkg::RES_W-1:0]   res_data,
    output logic [adcr_pkg::RES_W:0]     res_ext,
    output logic                         err_timeout,
    output logic                         spi_cs_n,
    output logic                         spi_sclk,
    output logic                         spi_mosi,
    input  logic                         spi_miso
);
    import adcr_pkg::*;

    localparam int QW = CNT_W + 1;
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    seq_state_t          state_q;
    logic [CTRL_W-1:0]   ctrl_q, ctrl_nx;
    logic [QW-1:0]       ncv_q, q_q;
    logic [3:0]          ph_q;
    logic                uni_q, strm_q, fin_q, mosi_q, err_q;
    logic [TW-1:0]       tmr_q;
    logic                busy, accept, abort, run, allow_rise, last_edge;
    logic                tick, rise_ev, fall_ev;
    logic                tx_bit, rx_en, rx_last;

    assign ctrl_nx     = make_ctrl(req_chan, req_unipolar, req_single);
    assign busy        = (state_q != ST_IDLE);
    assign accept      = req_valid && !busy;
    assign abort       = busy && (tmr_q == TW'(TIMEOUT_CYC - 1));
    assign run         = busy && !abort;
    assign allow_rise  = (state_q == ST_RUN) && !fin_q;
    assign last_edge   = strm_q ? (q_q == ncv_q && ph_q == 4'd7)
                                : (q_q == QW'(2) && ph_q == 4'd3);
    assign req_ready   = !busy;
    assign spi_cs_n    = !busy;
    assign spi_mosi    = mosi_q;
    assign err_timeout = err_q;

    adcr_sclk_gen #(.DIV_HALF(DIV_HALF)) i_sclk (
        .clk(clk), .rst_n(rst_n), .run(run), .allow_rise(allow_rise),
        .sclk(spi_sclk), .tick(tick), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    adcr_slot_map #(.CNT_W(CNT_W)) i_map (
        .ph(ph_q), .q(q_q), .n_conv(ncv_q), .ctrl(ctrl_q),
        .tx_bit(tx_bit), .rx_en(rx_en), .rx_last(rx_last)
    );

    adcr_rx_capture i_rx (
        .clk(clk), .rst_n(rst_n), .sample(rise_ev && rx_en), .last(rx_last),
        .miso(spi_miso), .uni(uni_q), .res_valid(res_valid),
        .res_data(res_data), .res_ext(res_ext)
    );

    // Transaction sequencing: accept, edge bookkeeping, tail, timeout abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            ncv_q   <= QW'(1);
            uni_q   <= 1'b0;
            strm_q  <= 1'b0;
            ph_q    <= '0;
            q_q     <= '0;
            fin_q   <= 1'b0;
            mosi_q  <= 1'b0;
            tmr_q   <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            state_q <= ST_RUN;
            ctrl_q  <= ctrl_nx;
            ncv_q   <= req_stream ? QW'(req_count) + QW'(1) : QW'(1);
            uni_q   <= req_unipolar;
            strm_q  <= req_stream;
            ph_q    <= '0;
            q_q     <= '0;
            fin_q   <= 1'b0;
            mosi_q  <= ctrl_nx[CTRL_W-1];
            tmr_q   <= '0;
            err_q   <= 1'b0;
        end else if (abort) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
            mosi_q  <= 1'b0;
            fin_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    tmr_q <= tmr_q + TW'(1);
                    if (rise_ev) begin
                        if (last_edge) fin_q <= 1'b1;
                        if (ph_q == 4'(SLOT_LEN - 1)) begin
                            ph_q <= '0;
                            q_q  <= q_q + QW'(1);
                        end else begin
                            ph_q <= ph_q + 4'd1;
                        end
                    end
                    if (fall_ev) begin
                        if (fin_q) begin
                            state_q <= ST_TAIL;
                            mosi_q  <= 1'b0;
                        end else begin
                            mosi_q <= tx_bit;
                        end
                    end
                end
                ST_TAIL: begin
                    tmr_q <= tmr_q + TW'(1);
                    if (tick) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_CS_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R1
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R1
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(ctrl_q)); // R8
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (spi_cs_n && !spi_sclk)); // R9
    AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !spi_cs_n); // R5
endmodule

// File: tb/test_adc_spi_reader.sv
`timescale 1ns/1ps
module test_adc_spi_reader;
    localparam int DIV = 2;
    localparam int TMO = 600;
    localparam int CW  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_single = 1'b0, req_unipolar = 1'b0, req_stream = 1'b0;
    logic [2:0] req_chan = '0;
    logic [CW-1:0] req_count = '0;
    logic req_ready, res_valid, err_timeout, spi_cs_n, spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;
    logic [7:0] res_data;
    logic [8:0] res_ext;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int rise_cnt = 0, ctl_seen = 0, res_total = 0, res_idx = 0;
    logic [7:0] vals [16];
    logic [7:0] exp_ctrl = '0;
    bit cur_uni = 1'b0, cur_strm = 1'b0;

    always #4 clk = ~clk;

    adc_spi_reader #(.DIV_HALF(DIV), .TIMEOUT_CYC(TMO), .CNT_W(CW)) i_adc_spi_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_single(req_single), .req_unipolar(req_unipolar),
        .req_stream(req_stream), .req_count(req_count), .res_valid(res_valid),
        .res_data(res_data), .res_ext(res_ext), .err_timeout(err_timeout),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl_of(input logic [2:0] ch, input bit uni, input bit sgl);
        return {1'b1, ch, uni, sgl, 2'b11};
    endfunction

    function automatic logic [8:0] ext_of(input logic [7:0] v, input bit uni);
        return uni ? {1'b0, v} : {v[7], v};
    endfunction

    // Behavioural converter: receives command bytes on rising edges, returns results on falling edges
    initial begin
        int in_cnt = 0, pend = 0, out_left = 0, slv_conv = 0;
        logic [7:0] in_sh = '0, out_sh = '0;
        forever begin
            @(spi_sclk or spi_cs_n);
            if (spi_cs_n) begin
                in_cnt = 0; pend = 0; out_left = 0; slv_conv = 0;
                spi_miso <= 1'b0;
            end else if (spi_sclk) begin
                rise_cnt++;
                if (in_cnt == 0) begin
                    if (spi_mosi) begin in_cnt = 1; in_sh = 8'h01; end
                end else begin
                    in_sh = {in_sh[6:0], spi_mosi};
                    in_cnt++;
                    if (in_cnt == 8) begin
                        check(in_sh == exp_ctrl, "R2 command byte", int'(in_sh), int'(exp_ctrl));
                        ctl_seen++;
                        in_cnt = 0;
                        pend = 3;
                    end
                end
            end else begin
                if (out_left > 0) begin
                    out_sh = {out_sh[6:0], 1'b0};
                    spi_miso <= out_sh[7];
                    out_left--;
                end else begin
                    spi_miso <= 1'b0;
                end
                if (pend > 0) begin
                    pend--;
                    if (pend == 0) begin
                        out_sh = vals[slv_conv[3:0]];
                        slv_conv++;
                        spi_miso <= out_sh[7];
                        out_left = 7;
                    end
                end
            end
        end
    end

    // Monitor: results, clock phase lengths, chip-select margins, watchdog
    initial begin
        int hi_cnt = 0, pre_cnt = 0, post_cnt = 0;
        bit seen_rise = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
            if (res_valid) begin
                check(res_data == vals[res_idx[3:0]], cur_strm ? "R4 stream result" : "R3 byte result",
                      int'(res_data), int'(vals[res_idx[3:0]]));
                check(res_ext == ext_of(vals[res_idx[3:0]], cur_uni), "R6 extension",
                      int'(res_ext), int'(ext_of(vals[res_idx[3:0]], cur_uni)));
                res_idx++;
                res_total++;
            end
            if (spi_cs_n) begin
                if (post_cnt != 0 && !err_timeout)
                    check(post_cnt == DIV, "R7 cs hold after last fall", post_cnt, DIV);
                res_idx = 0; hi_cnt = 0; pre_cnt = 0; post_cnt = 0; seen_rise = 1'b0;
            end else if (spi_sclk) begin
                if (!seen_rise) check(pre_cnt == DIV, "R7 cs setup before first rise", pre_cnt, DIV);
                seen_rise = 1'b1;
                hi_cnt++;
                post_cnt = 0;
            end else begin
                if (hi_cnt != 0) begin
                    check(hi_cnt == DIV, "R7 sclk high phase", hi_cnt, DIV);
                    hi_cnt = 0;
                end
                if (!seen_rise) pre_cnt++;
                post_cnt++;
            end
        end
    end

    task automatic fill_rand();
        for (int i = 0; i < 16; i++) vals[i] = 8'($urandom);
    endtask

    task automatic issue(input logic [2:0] ch, input bit sgl, input bit uni, input bit strm, input int cnt);
        exp_ctrl = ctrl_of(ch, uni, sgl);
        cur_uni = uni; cur_strm = strm;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_single = sgl; req_unipolar = uni;
        req_stream = strm; req_count = CW'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_req(input logic [2:0] ch, input bit sgl, input bit uni, input bit strm, input int cnt);
        int r0, c0, v0, n;
        n = strm ? cnt + 1 : 1;
        r0 = rise_cnt; c0 = ctl_seen; v0 = res_total;
        issue(ch, sgl, uni, strm, cnt);
        wait (spi_cs_n == 1'b1);
        @(negedge clk);
        if (strm) check(rise_cnt - r0 == 10 * n + 8, "R4 edges per window", rise_cnt - r0, 10 * n + 8);
        else      check(rise_cnt - r0 == 24, "R3 edges per window", rise_cnt - r0, 24);
        check(ctl_seen - c0 == n, strm ? "R4 command count" : "R3 command count", ctl_seen - c0, n);
        check(res_total - v0 == n, "R5 result count", res_total - v0, n);
        check(err_timeout == 1'b0, "R9 no error", int'(err_timeout), 0);
        check(req_ready == 1'b1, "R8 ready after done", int'(req_ready), 1);
    endtask

    initial begin
        int r0, c0, v0;
        void'($urandom(32'h5EED_0A1C));
        fill_rand();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(spi_cs_n == 1'b1, "R10 cs_n", int'(spi_cs_n), 1);
        check(spi_sclk == 1'b0, "R10 sclk", int'(spi_sclk), 0);
        check(spi_mosi == 1'b0, "R10 mosi", int'(spi_mosi), 0);
        check(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
        check(res_valid == 1'b0, "R10 valid", int'(res_valid), 0);
        check(err_timeout == 1'b0, "R10 err", int'(err_timeout), 0);

        // Directed polarity corners, byte framing (R3, R6)
        vals[0] = 8'h80; run_req(3'd7, 1'b1, 1'b0, 1'b0, 0);
        vals[0] = 8'h7F; run_req(3'd0, 1'b0, 1'b0, 1'b0, 0);
        vals[0] = 8'hFF; run_req(3'd5, 1'b1, 1'b1, 1'b0, 0);
        vals[0] = 8'h00; run_req(3'd2, 1'b0, 1'b1, 1'b0, 0);

        // Directed streaming corners (R4): single conversion and mixed codes
        vals[0] = 8'hFF; vals[1] = 8'h80; vals[2] = 8'h01;
        run_req(3'd4, 1'b1, 1'b0, 1'b1, 0);
        run_req(3'd1, 1'b1, 1'b0, 1'b1, 2);

        // Constrained random mix of both framings
        for (int t = 0; t < 24; t++) begin
            fill_rand();
            run_req(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 12));
        end

        // R8: a request while busy is ignored
        fill_rand();
        r0 = rise_cnt; c0 = ctl_seen; v0 = res_total;
        issue(3'd5, 1'b1, 1'b1, 1'b1, 3);
        repeat (20) @(negedge clk);
        check(req_ready == 1'b0, "R8 ready low while busy", int'(req_ready), 0);
        req_valid = 1'b1; req_chan = 3'd2; req_single = 1'b0; req_unipolar = 1'b0; req_count = '0;
        @(negedge clk);
        req_valid = 1'b0;
        wait (spi_cs_n == 1'b1);
        @(negedge clk);
        check(ctl_seen - c0 == 4, "R8 command count unchanged", ctl_seen - c0, 4);
        check(rise_cnt - r0 == 48, "R8 edge count unchanged", rise_cnt - r0, 48);
        check(res_total - v0 == 4, "R8 result count unchanged", res_total - v0, 4);
        repeat (5) @(negedge clk);
        check(spi_cs_n == 1'b1, "R8 busy request not queued", int'(spi_cs_n), 1);

        // R9: 16 conversions need 168 edges (about 672 clocks) > 600; rises at
        // accept+2+4*(e-1), abort at accept+600, so results end after edge 148 (k=13)
        fill_rand();
        v0 = res_total;
        issue(3'd6, 1'b1, 1'b1, 1'b1, 15);
        wait (spi_cs_n == 1'b1);
        @(negedge clk);
        check(err_timeout == 1'b1, "R9 error set", int'(err_timeout), 1);
        check(spi_sclk == 1'b0, "R9 sclk low after abort", int'(spi_sclk), 0);
        check(res_total - v0 == 14, "R9 results before abort", res_total - v0, 14);
        repeat (10) @(negedge clk);
        check(err_timeout == 1'b1, "R9 error held", int'(err_timeout), 1);
        fill_rand();
        run_req(3'd3, 1'b1, 1'b1, 1'b0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule